// File: doc/BRIEF.md
# Quad byte-lane SIMD multiplier

This execute unit multiplies the four 8-bit lanes of one 32-bit extension register by the four matching lanes of a second one. Each product is cut to 16 bits. The four products are split across two destination registers. The unit decodes its own register indices and a mode selector from the instruction word. It holds the sixteen-entry extension register file itself.

A two-bit selector decides how the first source's bytes are read. The code `10` reads them as signed; every other code reads them as unsigned. The second source's bytes are always read as unsigned, so the signed mode is a signed-by-unsigned multiply.

An instruction is presented for one cycle with the `issue` strobe. Results are committed at that clock edge, and `done` pulses in the following cycle. When the extension-enable input is low, the instruction still completes and pulses `done`, but neither destination changes. A load port lets neighbouring logic fill registers, and a read port lets it inspect them.

Top module: `quad_lane_mul`

## Requirements
- R1: Instruction fields are decoded at fixed positions: first destination in bits 9:6, first source in bits 13:10, second source in bits 17:14, second destination in bits 21:18, and mode selector in bits 23:22. All other instruction bits are ignored.
- R2: For selector values 00, 01 and 11, each byte of the first source is zero-extended before it is multiplied.
- R3: For selector value 10, each byte of the first source is sign-extended before it is multiplied.
- R4: Each byte of the second source is zero-extended for every selector value.
- R5: Lane i (bits 8i+7:8i) of the first source multiplies lane i of the second source, and only the low 16 bits of each product are kept.
- R6: The second destination receives the lane 0 product in bits 15:0 and the lane 1 product in bits 31:16.
- R7: The first destination receives the lane 2 product in bits 15:0 and the lane 3 product in bits 31:16.
- R8: When `ext_en` is low during `issue`, no register changes.
- R9: Both sources are read before any destination is written, so a destination that names a source register uses the source's old value.
- R10: When both destination indices are equal, that register ends up holding the lanes 2/3 word.
- R11: Register 0 always reads as zero, and writes to it from the instruction or the load port are dropped.
- R12: Results are written at the clock edge that samples `issue`. `done` is high for exactly the one cycle after that edge, and is low otherwise.
- R13: Reset clears every register to zero and drives `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction valid strobe, one cycle per instruction |
| instr | input | 32 | Instruction word |
| ext_en | input | 1 | Extension-enable bit from the control register |
| ld_we | input | 1 | Load-port write enable |
| ld_idx | input | 4 | Load-port register index |
| ld_data | input | 32 | Load-port write data |
| peek_idx | input | 4 | Read-port register index |
| peek_data | output | 32 | Read-port data, combinational from the register file |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every register result lands at the edge that samples `issue`, and `done` follows one cycle later. The bench therefore checks register contents only after it sees `done`, at the falling edge that follows that rising edge. It reads back every destination and source index of the instruction, one after another, through the read port. Each expected item carries the number of its instruction, so the monitor compares only the items that belong to the pulse it is handling. The monitor also compares `done` in every cycle against a one-edge-delayed copy of the strobe, which exposes a pulse that comes early, comes late or is missing.

// File: rtl/qlm_pkg.sv
package qlm_pkg;

    localparam int XLEN     = 32;
    localparam int LANE_W   = 8;
    localparam int LANES    = XLEN / LANE_W;
    localparam int HALF     = LANES / 2;
    localparam int PROD_W   = 2 * LANE_W;
    localparam int REG_CNT  = 16;
    localparam int IDX_W    = $clog2(REG_CNT);
    localparam int SEL_W    = 2;

    // instruction field positions (least significant bit of each field)
    localparam int DHI_LSB  = 6;
    localparam int SRCA_LSB = 10;
    localparam int SRCB_LSB = 14;
    localparam int DLO_LSB  = 18;
    localparam int SEL_LSB  = 22;

    localparam logic [SEL_W-1:0] SEL_SIGNED = 2'b10;

    typedef logic [IDX_W-1:0] ridx_t;
    typedef logic [XLEN-1:0]  word_t;

    typedef struct packed {
        ridx_t dst_hi;    // receives lanes HALF..LANES-1
        ridx_t src_a;     // optionally signed operand
        ridx_t src_b;     // always unsigned operand
        ridx_t dst_lo;    // receives lanes 0..HALF-1
        logic  signed_a;
    } qlm_op_t;

    function automatic logic [PROD_W-1:0] lane_product(
        input logic [LANE_W-1:0] x,
        input logic [LANE_W-1:0] y,
        input logic              sgn
    );
        logic [PROD_W-1:0] ex;
        logic [PROD_W-1:0] ey;
        ex = {{LANE_W{sgn & x[LANE_W-1]}}, x};
        ey = {{LANE_W{1'b0}}, y};
        return ex * ey;
    endfunction

endpackage

// File: rtl/qlm_decode.sv
module qlm_decode
    import qlm_pkg::*;
(
    input  word_t   instr,
    output qlm_op_t op
);
    logic unused_fields;

    always_comb begin
        op.dst_hi   = instr[DHI_LSB  +: IDX_W];
        op.src_a    = instr[SRCA_LSB +: IDX_W];
        op.src_b    = instr[SRCB_LSB +: IDX_W];
        op.dst_lo   = instr[DLO_LSB  +: IDX_W];
        op.signed_a = (instr[SEL_LSB +: SEL_W] == SEL_SIGNED);
    end

    assign unused_fields = ^{instr[XLEN-1:SEL_LSB+SEL_W], instr[DHI_LSB-1:0]};
endmodule

// File: rtl/qlm_lanes.sv
module qlm_lanes
    import qlm_pkg::*;
(
    input  word_t a,
    input  word_t b,
    input  logic  signed_a,
    output word_t lo_word,
    output word_t hi_word
);
    logic [PROD_W-1:0] prod [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign prod[g] = lane_product(a[g*LANE_W +: LANE_W],
                                      b[g*LANE_W +: LANE_W], signed_a);
    end

    for (genvar h = 0; h < HALF; h++) begin : g_pack
        assign lo_word[h*PROD_W +: PROD_W] = prod[h];
        assign hi_word[h*PROD_W +: PROD_W] = prod[h+HALF];
    end
endmodule

// File: rtl/qlm_regfile.sv
module qlm_regfile
    import qlm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ridx_t rd_a_idx,
    output word_t rd_a,
    input  ridx_t rd_b_idx,
    output word_t rd_b,
    input  ridx_t rd_p_idx,
    output word_t rd_p,
    input  logic  ld_we,
    input  ridx_t ld_idx,
    input  word_t ld_data,
    input  logic  we_lo,
    input  ridx_t lo_idx,
    input  word_t lo_data,
    input  logic  we_hi,
    input  ridx_t hi_idx,
    input  word_t hi_data
);
    logic [REG_CNT-1:0][XLEN-1:0] mem;

    // later statements win: load, then low word, then high word
    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else begin
            if (ld_we && ld_idx != '0) mem[ld_idx] <= ld_data;
            if (we_lo && lo_idx != '0) mem[lo_idx] <= lo_data;
            if (we_hi && hi_idx != '0) mem[hi_idx] <= hi_data;
        end
    end

    assign rd_a = mem[rd_a_idx];
    assign rd_b = mem[rd_b_idx];
    assign rd_p = mem[rd_p_idx];

    // R8
    rf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ld_we && !we_lo && !we_hi) |=> $stable(mem));
endmodule

// File: rtl/quad_lane_mul.sv
module quad_lane_mul
    import qlm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [XLEN-1:0]   instr,
    input  logic              ext_en,
    input  logic              ld_we,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [XLEN-1:0]   ld_data,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic [XLEN-1:0]   peek_data,
    output logic              done
);
    qlm_op_t op;
    word_t   src_a_val;
    word_t   src_b_val;
    word_t   lo_word;
    word_t   hi_word;
    logic    commit;

    qlm_decode u_dec (
        .instr (instr),
        .op    (op)
    );

    qlm_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (op.src_a),
        .rd_a     (src_a_val),
        .rd_b_idx (op.src_b),
        .rd_b     (src_b_val),
        .rd_p_idx (peek_idx),
        .rd_p     (peek_data),
        .ld_we    (ld_we),
        .ld_idx   (ld_idx),
        .ld_data  (ld_data),
        .we_lo    (commit),
        .lo_idx   (op.dst_lo),
        .lo_data  (lo_word),
        .we_hi    (commit),
        .hi_idx   (op.dst_hi),
        .hi_data  (hi_word)
    );

    qlm_lanes u_lanes (
        .a        (src_a_val),
        .b        (src_b_val),
        .signed_a (op.signed_a),
        .lo_word  (lo_word),
        .hi_word  (hi_word)
    );

    assign commit = issue && ext_en;

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= issue;
    end

    // R12
    done_follows_chk: assert property (@(posedge clk) disable iff (rst)
        issue |=> done);

    // R12
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !issue |=> !done);

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        // R4
        zero_lane_chk: assert property (@(posedge clk) disable iff (rst)
            (src_b_val[g*LANE_W +: LANE_W] == '0) |->
            ({hi_word, lo_word}[g*PROD_W +: PROD_W] == '0));

        // R3
        sign_unit_chk: assert property (@(posedge clk) disable iff (rst)
            (op.signed_a && src_b_val[g*LANE_W +: LANE_W] == LANE_W'(1)) |->
            ({hi_word, lo_word}[g*PROD_W +: PROD_W] ==
             {{LANE_W{src_a_val[g*LANE_W+LANE_W-1]}}, src_a_val[g*LANE_W +: LANE_W]}));
    end
endmodule

// File: tb/sim_quad_lane_mul.sv
`timescale 1ns/100ps
module sim_quad_lane_mul;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [31:0] instr = '0;
    logic        ext_en = 1'b1;
    logic        ld_we = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [3:0]  peek_idx = '0;
    logic [31:0] peek_data;
    logic        done;

    quad_lane_mul u0 (
        .clk(clk), .rst(rst), .issue(issue), .instr(instr), .ext_en(ext_en),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .peek_idx(peek_idx), .peek_data(peek_data), .done(done)
    );

    always #2 clk = ~clk;

    typedef struct {
        int          op;
        logic [3:0]  idx;
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t       sbq[$];
    logic [31:0] model [16];
    int          checks = 0;
    int          errors = 0;
    int          ops_sent = 0;
    int          ops_seen = 0;
    logic        iss_d = 1'b0;
    bit          finished = 0;

    always @(posedge clk) iss_d <= issue;

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_lane(logic [7:0] x, logic [7:0] y, bit sgn);
        int xv;
        int p;
        xv = sgn ? int'($signed(x)) : int'(x);
        p  = xv * int'(y);
        return p[15:0];
    endfunction

    function automatic logic [31:0] mk(logic [1:0] sel, logic [3:0] dh, logic [3:0] sa,
                                       logic [3:0] sb, logic [3:0] dl);
        return {8'hA5, sel, dl, sb, sa, dh, 6'h2A};
    endfunction

    task automatic load(logic [3:0] idx, logic [31:0] val);
        @(negedge clk);
        ld_we = 1'b1; ld_idx = idx; ld_data = val;
        @(negedge clk);
        ld_we = 1'b0;
        if (idx != 0) model[idx] = val;
    endtask

    task automatic push(logic [3:0] idx, string tag);
        item_t it;
        it.op = ops_sent; it.idx = idx; it.val = model[idx]; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic run(logic [1:0] sel, logic [3:0] dh, logic [3:0] sa, logic [3:0] sb,
                       logic [3:0] dl, bit en, string tag);
        logic [31:0] a, b, lo, hi;
        bit sgn;
        a = model[sa]; b = model[sb]; sgn = (sel == 2'b10);
        lo = {ref_lane(a[15:8], b[15:8], sgn), ref_lane(a[7:0], b[7:0], sgn)};
        hi = {ref_lane(a[31:24], b[31:24], sgn), ref_lane(a[23:16], b[23:16], sgn)};
        @(negedge clk);
        ext_en = en;
        if (en) begin
            if (dl != 0) model[dl] = lo;   // R6
            if (dh != 0) model[dh] = hi;   // R7, R10 priority
        end
        push(dh, {tag, " dst_hi"});
        push(dl, {tag, " dst_lo"});
        push(sa, {tag, " src_a"});
        push(sb, {tag, " src_b"});
        instr = mk(sel, dh, sa, sb, dl);
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        ops_sent++;
        @(negedge clk);
    endtask

    // monitor: pops the items of each completed instruction
    initial begin
        forever begin
            @(negedge clk);
            #0.5;
            if (!rst) begin
                if (done || iss_d)
                    check(done === iss_d, "R12 done pulse", {31'd0, done}, {31'd0, iss_d});
                if (done) begin
                    while (sbq.size() > 0 && sbq[0].op == ops_seen) begin
                        item_t it;
                        it = sbq.pop_front();
                        peek_idx = it.idx;
                        #0.1;
                        check(peek_data === it.val, it.tag, peek_data, it.val);
                    end
                    ops_seen++;
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual %0d expected %0d", ops_seen, ops_sent);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13: registers and done after reset
        check(done === 1'b0, "R13 done after reset", {31'd0, done}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            peek_idx = 4'(i);
            #0.1;
            check(peek_data === 32'd0, "R13 register after reset", peek_data, 32'd0);
        end

        load(1, 32'hFF80_7F03);
        load(2, 32'h0302_FF10);
        load(3, 32'h80FF_0201);
        load(4, 32'h1122_3344);

        run(2'b00, 5, 1, 2, 6, 1, "R1 R2 R5 R6 R7 unsigned sel00");
        run(2'b10, 7, 1, 2, 8, 1, "R3 signed sel10");
        run(2'b01, 9, 1, 2, 10, 1, "R2 sel01");
        run(2'b11, 11, 1, 3, 12, 1, "R2 sel11");
        run(2'b10, 13, 1, 3, 14, 1, "R4 second source zero-extended");
        run(2'b10, 5, 3, 1, 6, 0, "R8 disabled");
        run(2'b10, 1, 1, 2, 2, 1, "R9 destinations overlap sources");
        run(2'b00, 13, 3, 4, 13, 1, "R10 equal destinations");
        run(2'b00, 0, 3, 4, 14, 1, "R11 destination zero");
        run(2'b10, 15, 0, 3, 0, 1, "R11 source zero");
        run(2'b10, 9, 4, 3, 10, 1, "R5 mixed lanes");

        // R11: load to register 0 is dropped
        load(0, 32'hDEAD_BEEF);
        peek_idx = 4'd0;
        #0.1;
        check(peek_data === 32'd0, "R11 load to register 0", peek_data, 32'd0);

        repeat (4) @(negedge clk);
        check(ops_seen == ops_sent, "R12 every instruction completed",
              32'(ops_seen), 32'(ops_sent));
        check(sbq.size() == 0, "R12 scoreboard drained", 32'(sbq.size()), 32'd0);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule